// File: doc/BRIEF.md
# Indirect Table Access Engine

This block gives a CPU indirect access to an 80-bit-wide, 256-entry table kept in on-chip RAM. The table is far wider than the 16-bit CPU bus, so the CPU works through a small register bank. Five transfer registers together hold one table entry, and five mask registers match them bit for bit. An index register names the entry. A control register selects the target table, sets the direction of the transfer and holds a start bit.

A read transfer copies the whole entry into the transfer registers. A write transfer is done as a read-modify-write. The engine fetches the entry and merges the transfer registers into it wherever the mask bit is 0. Where the mask bit is 1, the stored bit is kept. The merged entry is then written back. The start bit clears itself when the transfer ends, and it also serves as a busy flag. While it is set, CPU register writes are dropped, so the operands cannot change during a transfer.

Top module: `tbl_access_engine`

## Requirements
- R1: After reset, every register (addresses 0 to 11) reads as 0, and the busy flag is 0.
- R2: Register map, with each read returning data one cycle after the address is presented:
  - Addresses 0 to 4 are transfer words 0 to 4. Word k covers entry bits 16k+15 down to 16k.
  - Addresses 5 to 9 are the matching mask words.
  - Address 10 is the index register. Its low 8 bits are writable and its upper bits read as 0.
  - Address 11 is the control register: select field in bits 4..0, start in bit 5, direction in bit 6 (1 = write), busy (read-only) in bit 7, and 0 in the other bits.
- R3: A read transfer overwrites all five transfer words with the stored bits of the addressed entry.
- R4: A write transfer sets each entry bit whose mask bit is 0 to the transfer register bit, and leaves each entry bit whose mask bit is 1 unchanged.
- R5: Index values 0 to 255 address separate entries. Entries 127 and 128 (the edge between the two halves), 0 and 255 do not alias.
- R6: When the start bit is set with select code 3, busy reads 1 for exactly two cycles. The start bit then clears by itself.
- R7: When the start bit is set with a select code other than 3, the table and the transfer words are left unchanged, and the start bit clears after one cycle.
- R8: While busy is 1, CPU writes to the transfer, mask, index and control registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 4 | Register address |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data, one cycle after the address |

## Verification
The assertions check on every cycle that a RAM write never changes a masked bit, and that the RAM is written only during a write transfer with select code 3. They also check that the start bit lasts two cycles for a valid select and one cycle for an invalid one, and that index, mask, select and direction stay put when the CPU writes during a transfer. Only the bench scenarios can show that merged data really lands in the right entry, with no aliasing between indices. The same holds for the exact register map, the one-cycle read latency, and the contents left behind by rejected transfers.

// File: rtl/tae_pkg.sv
package tae_pkg;
  // control register field positions
  localparam int unsigned CTL_SEL_W   = 5;
  localparam int unsigned CTL_GO_BIT  = 5;
  localparam int unsigned CTL_DIR_BIT = 6;

  typedef enum logic [0:0] {
    SQ_IDLE  = 1'b0,
    SQ_FETCH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tae_ram.sv
module tae_ram #(
  parameter int unsigned WIDTH = 80,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             re,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem_q[addr];
  end
endmodule

// File: rtl/tae_regfile.sv
module tae_regfile
  import tae_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned ENTRY_W  = WORD_W * NUM_WORDS,
  localparam int unsigned IDX_ADDR = 2 * NUM_WORDS,
  localparam int unsigned CTL_ADDR = 2 * NUM_WORDS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 cpu_we,
  input  logic [WORD_W-1:0]    cpu_wdata,
  output logic [WORD_W-1:0]    cpu_rdata,
  input  logic                 done_i,
  input  logic                 load_en_i,
  input  logic [ENTRY_W-1:0]   load_data_i,
  output logic [ENTRY_W-1:0]   xfer_o,
  output logic [ENTRY_W-1:0]   mask_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [CTL_SEL_W-1:0] sel_o,
  output logic                 dir_o,
  output logic                 go_o
);
  logic wr_ok;
  assign wr_ok = cpu_we && !go_o;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] xfer_q, xfer_d, mask_q;
    logic              xfer_en, mask_en;

    always_comb begin
      mask_en = wr_ok && (cpu_addr == ADDR_W'(NUM_WORDS + w));
      xfer_en = load_en_i || (wr_ok && (cpu_addr == ADDR_W'(w)));
      xfer_d  = load_en_i ? load_data_i[w*WORD_W +: WORD_W] : cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       xfer_q <= '0;
      else if (xfer_en) xfer_q <= xfer_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_en) mask_q <= cpu_wdata;
    end

    assign xfer_o[w*WORD_W +: WORD_W] = xfer_q;
    assign mask_o[w*WORD_W +: WORD_W] = mask_q;
  end

  // index and control registers
  logic                 idx_en, ctl_en, go_en, go_d;
  logic [IDX_W-1:0]     idx_q;
  logic [CTL_SEL_W-1:0] sel_q;
  logic                 dir_q, go_q;

  always_comb begin
    idx_en = wr_ok && (cpu_addr == ADDR_W'(IDX_ADDR));
    ctl_en = wr_ok && (cpu_addr == ADDR_W'(CTL_ADDR));
    go_en  = ctl_en || done_i;
    go_d   = done_i ? 1'b0 : cpu_wdata[CTL_GO_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= cpu_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      dir_q <= 1'b0;
    end else if (ctl_en) begin
      sel_q <= cpu_wdata[CTL_SEL_W-1:0];
      dir_q <= cpu_wdata[CTL_DIR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     go_q <= 1'b0;
    else if (go_en) go_q <= go_d;
  end

  assign idx_o = idx_q;
  assign sel_o = sel_q;
  assign dir_o = dir_q;
  assign go_o  = go_q;

  // read path, one cycle of latency
  logic [WORD_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (cpu_addr == ADDR_W'(w))             rd_d = xfer_o[w*WORD_W +: WORD_W];
      if (cpu_addr == ADDR_W'(NUM_WORDS + w)) rd_d = mask_o[w*WORD_W +: WORD_W];
    end
    if (cpu_addr == ADDR_W'(IDX_ADDR)) rd_d = WORD_W'(idx_q);
    if (cpu_addr == ADDR_W'(CTL_ADDR)) rd_d = WORD_W'({go_q, dir_q, go_q, sel_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_rdata <= '0;
    else        cpu_rdata <= rd_d;
  end
endmodule

// File: rtl/tae_seq.sv
module tae_seq
  import tae_pkg::*;
#(
  parameter int unsigned ENTRY_W  = 80,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned SEL_CODE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_i,
  input  logic                 dir_i,
  input  logic [CTL_SEL_W-1:0] sel_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [ENTRY_W-1:0]   xfer_i,
  input  logic [ENTRY_W-1:0]   mask_i,
  input  logic [ENTRY_W-1:0]   ram_rdata_i,
  output logic                 ram_re_o,
  output logic                 ram_we_o,
  output logic [IDX_W-1:0]     ram_addr_o,
  output logic [ENTRY_W-1:0]   ram_wdata_o,
  output logic                 load_en_o,
  output logic                 done_o
);
  seq_state_e state_q, state_d;
  logic       sel_ok;

  assign sel_ok = (sel_i == CTL_SEL_W'(SEL_CODE));

  always_comb begin
    state_d   = state_q;
    ram_re_o  = 1'b0;
    ram_we_o  = 1'b0;
    load_en_o = 1'b0;
    done_o    = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (go_i) begin
          if (sel_ok) begin
            ram_re_o = 1'b1;
            state_d  = SQ_FETCH;
          end else begin
            done_o = 1'b1;
          end
        end
      end
      SQ_FETCH: begin
        done_o    = 1'b1;
        state_d   = SQ_IDLE;
        ram_we_o  = dir_i;
        load_en_o = !dir_i;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign ram_addr_o  = idx_i;
  assign ram_wdata_o = (ram_rdata_i & mask_i) | (xfer_i & ~mask_i);
endmodule

// File: rtl/tbl_access_engine.sv
module tbl_access_engine
  import tae_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SEL_CODE  = 3,
  localparam int unsigned ENTRY_W  = WORD_W * NUM_WORDS,
  localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata
);
  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [ENTRY_W-1:0]   xfer_vec, mask_vec, ram_rdata, ram_wdata;
  logic [IDX_W-1:0]     idx, ram_addr;
  logic [CTL_SEL_W-1:0] sel;
  logic                 dir, go, done, load_en, ram_re, ram_we;

  tae_regfile #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .done_i(done), .load_en_i(load_en), .load_data_i(ram_rdata),
    .xfer_o(xfer_vec), .mask_o(mask_vec), .idx_o(idx), .sel_o(sel), .dir_o(dir), .go_o(go)
  );

  tae_seq #(
    .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .SEL_CODE(SEL_CODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .go_i(go), .dir_i(dir), .sel_i(sel), .idx_i(idx),
    .xfer_i(xfer_vec), .mask_i(mask_vec), .ram_rdata_i(ram_rdata),
    .ram_re_o(ram_re), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .load_en_o(load_en), .done_o(done)
  );

  tae_ram #(
    .WIDTH(ENTRY_W), .DEPTH(DEPTH)
  ) u_ram (
    .clk(clk), .re(ram_re), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );
endmodule

// File: rtl/tae_chk.sv
module tae_chk #(
  parameter int unsigned ENTRY_W  = 80,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned SEL_W    = 5,
  parameter int unsigned SEL_CODE = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_we,
  input logic               go,
  input logic               dir,
  input logic [SEL_W-1:0]   sel,
  input logic [IDX_W-1:0]   idx,
  input logic [ENTRY_W-1:0] mask,
  input logic               ram_we,
  input logic [ENTRY_W-1:0] ram_rdata,
  input logic [ENTRY_W-1:0] ram_wdata
);
  // R4
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (((ram_wdata ^ ram_rdata) & mask) == '0));

  // R7
  ram_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (go && dir && (sel == SEL_W'(SEL_CODE))));

  // R6
  good_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(go) && (sel == SEL_W'(SEL_CODE))) |=> go ##1 !go);

  // R7
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(go) && (sel != SEL_W'(SEL_CODE))) |=> !go);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cpu_we) |=> ($stable(idx) && $stable(mask) && $stable(sel) && $stable(dir)));
endmodule

bind tbl_access_engine tae_chk #(
  .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .SEL_W(tae_pkg::CTL_SEL_W), .SEL_CODE(SEL_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_we(cpu_we), .go(go), .dir(dir), .sel(sel),
  .idx(idx), .mask(mask_vec), .ram_we(ram_we), .ram_rdata(ram_rdata), .ram_wdata(ram_wdata)
);

// File: tb/test_tbl_access_engine.sv
module test_tbl_access_engine;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 8;

  logic        clk, rst_n, cpu_we;
  logic [3:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;

  tbl_access_engine i_tbl_access_engine (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [79:0] shadow [256];

  // vector: {idx[8], dir[1], data[80], mask[80]}
  localparam logic [168:0] VEC [NV] = '{
    {8'd0,   1'b1, 80'h0123_4567_89AB_CDEF_0F1E, 80'h0},
    {8'd255, 1'b1, 80'hFFFF_0000_A5A5_5A5A_1234, 80'h0},
    {8'd127, 1'b1, 80'hDEAD_BEEF_CAFE_F00D_8001, 80'h0},
    {8'd128, 1'b1, 80'h1111_2222_3333_4444_5555, 80'h0},
    {8'd0,   1'b1, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 80'hFF00_FF00_FF00_FF00_FF00},
    {8'd255, 1'b1, 80'h0,                        80'h0000_FFFF_0000_FFFF_0000},
    {8'd127, 1'b0, 80'h0,                        80'h0},
    {8'd128, 1'b1, 80'hAAAA_AAAA_AAAA_AAAA_AAAA, 80'hFFFF_FFFF_FFFF_FFFF_FFFF}
  };

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [3:0] a, output logic [15:0] d);
    cpu_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = cpu_rdata;
  endtask

  function automatic logic [15:0] ctl(input logic dir, input logic [4:0] sel);
    return {9'd0, dir, 1'b1, sel};
  endfunction

  task automatic wait_idle();
    logic [15:0] r;
    for (int i = 0; i < 20; i++) begin
      cpu_read(4'd11, r);
      if (!r[7]) return;
    end
  endtask

  task automatic start(input logic [7:0] idx, input logic dir, input logic [4:0] sel);
    cpu_write(4'd10, {8'd0, idx});
    cpu_write(4'd11, ctl(dir, sel));
  endtask

  task automatic load_words(input logic [79:0] data, input logic [79:0] mask);
    for (int w = 0; w < 5; w++) cpu_write(4'(w), data[w*16 +: 16]);
    for (int w = 0; w < 5; w++) cpu_write(4'(5 + w), mask[w*16 +: 16]);
  endtask

  task automatic read_words(output logic [79:0] v);
    logic [15:0] r;
    for (int w = 0; w < 5; w++) begin
      cpu_read(4'(w), r);
      v[w*16 +: 16] = r;
    end
  endtask

  task automatic fetch_entry(input logic [7:0] idx, output logic [79:0] v);
    start(idx, 1'b0, 5'd3);
    wait_idle();
    read_words(v);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] r, r1, r2, r3;
    logic [79:0] v;
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of every register
    for (int a = 0; a < 12; a++) begin
      cpu_read(4'(a), r);
      check("R1 reset value", 80'(r), 80'h0);
    end

    // R2: mask word readback, index width, control field layout
    cpu_write(4'd7, 16'hC3A5);
    cpu_read(4'd7, r);
    check("R2 mask word 2 readback", 80'(r), 80'hC3A5);
    cpu_write(4'd10, 16'hFFFF);
    cpu_read(4'd10, r);
    check("R2 index upper bits zero", 80'(r), 80'h00FF);
    cpu_write(4'd11, 16'h0049);  // dir=1, sel=9, no start
    cpu_read(4'd11, r);
    check("R2 control fields", 80'(r), 80'h0049);
    cpu_write(4'd7, 16'h0000);

    // table walk: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  idx;
      logic        dir;
      logic [79:0] data, mask;
      {idx, dir, data, mask} = VEC[i];
      load_words(data, mask);
      start(idx, dir, 5'd3);
      wait_idle();
      if (dir) begin
        shadow[idx] = (shadow[idx] & mask) | (data & ~mask);
        fetch_entry(idx, v);
        check(dir ? "R4 masked write merge" : "R3", v, shadow[idx]);
      end else begin
        read_words(v);
        check("R3 read fills transfer words", v, shadow[idx]);
      end
    end
    foreach (VEC[i]) begin
      logic [7:0] idx;
      idx = VEC[i][168:161];
      fetch_entry(idx, v);
      check("R5 entry independence", v, shadow[idx]);
    end

    // R6: busy lasts exactly two cycles for a valid select
    start(8'd0, 1'b0, 5'd3);
    cpu_read(4'd11, r1); cpu_read(4'd11, r2); cpu_read(4'd11, r3);
    check("R6 busy sequence", 80'({r1[7], r2[7], r3[7], r3[5]}), 80'b1100);

    // R7: invalid select, write direction, table untouched
    load_words(80'h5A5A_5A5A_5A5A_5A5A_5A5A, 80'h0);
    start(8'd0, 1'b1, 5'd4);
    cpu_read(4'd11, r1); cpu_read(4'd11, r2);
    check("R7 start clears after one cycle", 80'({r1[7], r2[7]}), 80'b10);
    fetch_entry(8'd0, v);
    check("R7 table untouched on bad select", v, shadow[0]);
    // R7: invalid select, read direction, transfer words untouched
    cpu_write(4'd0, 16'h1357);
    start(8'd255, 1'b0, 5'd2);
    wait_idle();
    cpu_read(4'd0, r);
    check("R7 transfer word untouched", 80'(r), 80'h1357);

    // R8: writes while busy are dropped
    load_words(80'h0, 80'hFFFF_FFFF_FFFF_FFFF_FFFF);
    start(8'd128, 1'b1, 5'd3);
    cpu_write(4'd10, 16'h0005);
    cpu_write(4'd0, 16'hBEEF);
    wait_idle();
    cpu_read(4'd10, r);
    check("R8 index write ignored while busy", 80'(r), 80'd128);
    start(8'd127, 1'b0, 5'd3);
    cpu_write(4'd6, 16'h1234);
    wait_idle();
    cpu_read(4'd6, r);
    check("R8 mask write ignored while busy", 80'(r), 80'hFFFF);
    read_words(v);
    check("R8 entry intact", v, shadow[127]);

    finish_run();
  end
endmodule